// File: doc/BRIEF.md
# USB Full-Speed Frame Timer

This block paces the 1 ms frames of a full-speed USB host. It advances on a one-cycle enable that marks each 12 MHz bit time, and only while the host is in its operational state. A down-counter holds the bit times left in the current frame. When it reaches zero it is reloaded from a programmable interval register, and a 16-bit frame number steps forward.

The interval register carries two fields. The frame interval sits in the low bits. The largest data packet that may still be started sits from bit 16 upward. After reset the interval is 11999, which gives 12000 bit times per frame. The packet field then defaults to six sevenths of the interval less 210, rounded down.

At each frame boundary the frame number is updated. In the same cycle as the new number, the block raises a start-of-frame event pulse and a token request. A frame-number overflow pulse comes with them whenever the top bit of the frame number flips, in either direction. A "packet fits" flag tells a scheduler whether the remaining time still covers the largest packet. The event pulses are meant for the interrupt status unit.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset the frame number is 0 and the remaining count equals the default interval. The register reads back the default interval in its low bits and the default packet limit (6*(interval-210)/7, or 0 below 210) from bit 16. All event pulses are low.
- R2: A register write stores the interval in bits [IVL_W-1:0] and the packet limit in bits [16+LP_W-1:16]. It reads back in the next cycle, and every other bit reads 0.
- R3: Each cycle with both run and bit_en high lowers a nonzero remaining count by one. A count of zero is instead reloaded with the interval, so a frame lasts interval+1 enabled bit times.
- R4: A write to the interval changes nothing in the current frame. The new value is first used at the next reload.
- R5: At each frame boundary the frame number rises by exactly one and wraps to 0 after its largest value.
- R6: sof_pulse and sof_token_req are high together for one cycle per frame boundary. This is the same cycle in which frame_num first shows the new value.
- R7: fn_ovf_pulse is high exactly in those start-of-frame cycles where the top bit of the frame number has changed, from 0 to 1 or from 1 to 0.
- R8: While run is low, or bit_en is low, the remaining count and the frame number hold and no event pulse is raised.
- R9: pkt_fits is high exactly when the remaining count is greater than or equal to the packet-limit field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe per full-speed bit time |
| run | input | 1 | Host controller is in the operational state |
| cfg_we | input | 1 | Write strobe for the interval register |
| cfg_wdata | input | 32 | Write data: interval in the low bits, packet limit from bit 16 |
| cfg_rdata | output | 32 | Current contents of the interval register |
| remain | output | IVL_W | Bit times left in the current frame |
| frame_num | output | FN_W | Current frame number |
| sof_pulse | output | 1 | Start-of-frame event |
| sof_token_req | output | 1 | Request to send a start-of-frame token |
| fn_ovf_pulse | output | 1 | Frame-number top-bit toggle event |
| pkt_fits | output | 1 | Remaining count is at least the packet limit |

## Verification
The bench builds the block with 8-bit interval, packet-limit and frame-number fields and a default interval of 239, which gives a default packet limit of 24. At these sizes the frame number crosses its top bit in both directions within a few hundred one-bit-time frames. The bench sweeps every interval from 0 to 7 under enable strides of one to three cycles, and it can follow every cycle of the full-length default frame. A cycle-accurate arithmetic model is compared on every cycle, alongside directed checks for a write in the middle of a frame and for gating.

// File: rtl/ufr_pkg.sv
package ufr_pkg;

    // Event outputs produced at a frame boundary.
    typedef struct packed {
        logic sof;
        logic fn_ovf;
    } frame_evt_t;

    // Default largest-packet limit derived from an interval value.
    function automatic int lp_default(input int ivl);
        if (ivl > 210)
            return (6 * (ivl - 210)) / 7;
        else
            return 0;
    endfunction

    localparam int LP_LSB = 16;

endpackage

// File: rtl/ufr_cfg_reg.sv
module ufr_cfg_reg
    import ufr_pkg::*;
#(
    parameter int IVL_W   = 14,
    parameter int LP_W    = 15,
    parameter int DEF_IVL = 11999
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [31:0]      wdata,
    output logic [IVL_W-1:0] ivl,
    output logic [LP_W-1:0]  lp,
    output logic [31:0]      rdata
);
    localparam int DEF_LP = lp_default(DEF_IVL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ivl <= IVL_W'(DEF_IVL);
            lp  <= LP_W'(DEF_LP);
        end else if (we) begin
            ivl <= wdata[IVL_W-1:0];
            lp  <= wdata[LP_LSB +: LP_W];
        end
    end

    assign rdata = (32'(lp) << LP_LSB) | 32'(ivl);
endmodule

// File: rtl/ufr_down_counter.sv
module ufr_down_counter #(
    parameter int IVL_W   = 14,
    parameter int DEF_IVL = 11999
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [IVL_W-1:0] reload_val,
    output logic [IVL_W-1:0] remain,
    output logic             wrap
);
    assign wrap = tick && (remain == '0);

    always_ff @(posedge clk) begin
        if (rst)
            remain <= IVL_W'(DEF_IVL);
        else if (wrap)
            remain <= reload_val;
        else if (tick)
            remain <= remain - 1'b1;
    end
endmodule

// File: rtl/ufr_frame_num.sv
module ufr_frame_num
    import ufr_pkg::*;
#(
    parameter int FN_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wrap,
    output logic [FN_W-1:0] frame_num,
    output frame_evt_t      evt
);
    logic [FN_W-1:0] fn_next;
    assign fn_next = frame_num + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_num <= '0;
            evt       <= '0;
        end else begin
            evt.sof    <= wrap;
            evt.fn_ovf <= wrap && (fn_next[FN_W-1] != frame_num[FN_W-1]);
            if (wrap)
                frame_num <= fn_next;
        end
    end
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
    import ufr_pkg::*;
#(
    parameter int IVL_W   = 14,
    parameter int LP_W    = 15,
    parameter int FN_W    = 16,
    parameter int DEF_IVL = 11999
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             run,
    input  logic             cfg_we,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    output logic [IVL_W-1:0] remain,
    output logic [FN_W-1:0]  frame_num,
    output logic             sof_pulse,
    output logic             sof_token_req,
    output logic             fn_ovf_pulse,
    output logic             pkt_fits
);
    localparam int CMP_W = (IVL_W > LP_W) ? IVL_W : LP_W;

    logic [IVL_W-1:0] ivl;
    logic [LP_W-1:0]  lp;
    logic             tick;
    logic             wrap;
    frame_evt_t       evt;

    assign tick = run & bit_en;

    ufr_cfg_reg #(.IVL_W(IVL_W), .LP_W(LP_W), .DEF_IVL(DEF_IVL)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
        .ivl(ivl), .lp(lp), .rdata(cfg_rdata)
    );

    ufr_down_counter #(.IVL_W(IVL_W), .DEF_IVL(DEF_IVL)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .reload_val(ivl),
        .remain(remain), .wrap(wrap)
    );

    ufr_frame_num #(.FN_W(FN_W)) u_fn (
        .clk(clk), .rst(rst), .wrap(wrap),
        .frame_num(frame_num), .evt(evt)
    );

    assign sof_pulse     = evt.sof;
    assign sof_token_req = evt.sof;
    assign fn_ovf_pulse  = evt.fn_ovf;
    assign pkt_fits      = CMP_W'(remain) >= CMP_W'(lp);
endmodule

// File: rtl/ufr_checker.sv
module ufr_checker #(
    parameter int IVL_W = 14,
    parameter int FN_W  = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             bit_en,
    input logic             run,
    input logic [IVL_W-1:0] remain,
    input logic [FN_W-1:0]  frame_num,
    input logic             sof_pulse,
    input logic             sof_token_req,
    input logic             fn_ovf_pulse
);
    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && bit_en && remain != '0) |=> remain == $past(remain) - 1'b1);

    // R5
    fn_step_chk: assert property (@(posedge clk) disable iff (rst)
        sof_pulse |-> frame_num == $past(frame_num) + 1'b1);

    // R5
    fn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sof_pulse |-> $stable(frame_num));

    // R6
    token_pair_chk: assert property (@(posedge clk) disable iff (rst)
        sof_pulse == sof_token_req);

    // R7
    ovf_with_sof_chk: assert property (@(posedge clk) disable iff (rst)
        fn_ovf_pulse |-> (sof_pulse && frame_num[FN_W-1] != $past(frame_num[FN_W-1])));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(run && bit_en) |=> ($stable(remain) && !sof_pulse));
endmodule

bind usb_frame_timer ufr_checker #(.IVL_W(IVL_W), .FN_W(FN_W)) u_ufr_checker (
    .clk(clk), .rst(rst), .bit_en(bit_en), .run(run), .remain(remain),
    .frame_num(frame_num), .sof_pulse(sof_pulse), .sof_token_req(sof_token_req),
    .fn_ovf_pulse(fn_ovf_pulse)
);

// File: tb/usb_frame_timer_test.sv
`timescale 1ns/1ps
module usb_frame_timer_test;
    localparam int IVL_W = 8;
    localparam int LP_W  = 8;
    localparam int FN_W  = 8;
    localparam int DEF_IVL = 239;
    localparam int DEF_LP  = 24;
    localparam int IMASK = (1 << IVL_W) - 1;
    localparam int LMASK = (1 << LP_W) - 1;
    localparam int FMASK = (1 << FN_W) - 1;

    logic clk = 0;
    logic rst = 1;
    logic bit_en = 0, run = 0, cfg_we = 0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [IVL_W-1:0] remain;
    logic [FN_W-1:0] frame_num;
    logic sof_pulse, sof_token_req, fn_ovf_pulse, pkt_fits;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    int m_rem, m_fn, m_ivl, m_lp;
    bit m_sof, m_ovf;
    int ovf_seen = 0;

    always #5 clk = ~clk;

    usb_frame_timer #(.IVL_W(IVL_W), .LP_W(LP_W), .FN_W(FN_W), .DEF_IVL(DEF_IVL)) uut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .run(run), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .remain(remain),
        .frame_num(frame_num), .sof_pulse(sof_pulse), .sof_token_req(sof_token_req),
        .fn_ovf_pulse(fn_ovf_pulse), .pkt_fits(pkt_fits)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        check(remain == m_rem, "R3 remain", remain, m_rem);
        check(frame_num == m_fn, "R5 frame_num", frame_num, m_fn);
        check(sof_pulse == m_sof, "R6 sof_pulse", sof_pulse, m_sof);
        check(sof_token_req == m_sof, "R6 sof_token_req", sof_token_req, m_sof);
        check(fn_ovf_pulse == m_ovf, "R7 fn_ovf_pulse", fn_ovf_pulse, m_ovf);
        check(pkt_fits == (m_rem >= m_lp), "R9 pkt_fits", pkt_fits, m_rem >= m_lp);
        check(cfg_rdata == 32'((m_lp << 16) | m_ivl), "R2 cfg_rdata", cfg_rdata, (m_lp << 16) | m_ivl);
    endtask

    task automatic step(input bit r, input bit e, input bit we, input logic [31:0] wd);
        bit b;
        run = r; bit_en = e; cfg_we = we; cfg_wdata = wd;
        @(posedge clk);
        b = r && e && (m_rem == 0);
        m_sof = b;
        m_ovf = b && ((((m_fn + 1) >> (FN_W-1)) & 1) != ((m_fn >> (FN_W-1)) & 1));
        if (b) begin
            m_fn  = (m_fn + 1) & FMASK;
            m_rem = m_ivl;
        end else if (r && e) begin
            m_rem = m_rem - 1;
        end
        if (we) begin
            m_ivl = int'(wd) & IMASK;
            m_lp  = int'(wd >> 16) & LMASK;
        end
        @(negedge clk);
        compare_all();
        if (fn_ovf_pulse) ovf_seen++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int rbefore, cnt, fn0, rem0;
        bit any_sof;
        m_rem = DEF_IVL; m_fn = 0; m_ivl = DEF_IVL; m_lp = DEF_LP; m_sof = 0; m_ovf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        check(frame_num == 0, "R1 frame_num", frame_num, 0);
        check(remain == DEF_IVL, "R1 remain", remain, DEF_IVL);
        check(cfg_rdata == 32'((DEF_LP << 16) | DEF_IVL), "R1 cfg_rdata", cfg_rdata, (DEF_LP << 16) | DEF_IVL);
        check(!sof_pulse && !sof_token_req && !fn_ovf_pulse, "R1 pulses", sof_pulse, 0);

        // Full default frame, bit_en every cycle
        for (int i = 0; i < 250; i++) step(1, 1, 0, 0);

        // R2 unused bits read zero
        step(1, 1, 1, 32'hFFFF_FFFF);
        check(cfg_rdata == 32'((LMASK << 16) | IMASK), "R2 mask", cfg_rdata, (LMASK << 16) | IMASK);

        // R3 sweep intervals and enable strides
        for (int n = 0; n < 8; n++) begin
            for (int s = 1; s <= 3; s++) begin
                step(1, 1, 1, 32'((n / 2) << 16 | n));
                for (int k = 0; k < (n + 1) * s * 3 + 300; k++)
                    step(1, (k % s) == 0, 0, 0);
            end
        end

        // R4 mid-frame write
        step(1, 1, 1, 32'((5 << 16) | 20));
        while (!sof_pulse) step(1, 1, 0, 0);
        for (int k = 0; k < 9; k++) step(1, 1, 0, 0);
        rbefore = int'(remain);
        cnt = 1;
        step(1, 1, 1, 32'((1 << 16) | 3));
        while (!sof_pulse) begin step(1, 1, 0, 0); cnt++; end
        check(cnt == rbefore + 1, "R4 current frame kept", cnt, rbefore + 1);
        cnt = 1;
        step(1, 1, 0, 0);
        while (!sof_pulse) begin step(1, 1, 0, 0); cnt++; end
        check(cnt == 4, "R4 new interval used", cnt, 4);

        // R8 gating
        fn0 = int'(frame_num); rem0 = int'(remain); any_sof = 0;
        for (int k = 0; k < 20; k++) begin step(0, 1, 0, 0); any_sof |= sof_pulse; end
        for (int k = 0; k < 20; k++) begin step(1, 0, 0, 0); any_sof |= sof_pulse; end
        check(int'(remain) == rem0, "R8 remain held", remain, rem0);
        check(int'(frame_num) == fn0, "R8 frame held", frame_num, fn0);
        check(!any_sof, "R8 no event", any_sof, 0);

        // R7 top-bit toggles both ways with one-bit-time frames
        ovf_seen = 0;
        step(1, 1, 1, 32'h0);
        for (int k = 0; k < 520; k++) step(1, 1, 0, 0);
        check(ovf_seen >= 4, "R7 toggles seen", ovf_seen, 4);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule